// File: doc/BRIEF.md
# MD5 Compression Core

This block applies the MD5 compression function to a single 512-bit block that has already been padded. The block arrives on one wide port as sixteen 32-bit little-endian words, with word j on bits 32j+31 down to 32j. A pulse on `start` while the core is idle captures the block and loads the working registers with the standard initial chaining values. The core then runs sixty-four steps, one per clock. There are four rounds of sixteen steps, and each round has its own boolean mixing function, its own message-word order and its own rotation schedule. A constant taken from a 64-entry table is added at each step.

A final cycle adds the initial chaining values into the working registers. It publishes the 128-bit digest and pulses `done` for one cycle. The digest stays unchanged until the next run completes. The core does not do message padding, chaining across several blocks or any comparison against a target hash. Those tasks belong to the logic around it.

Top module: `md5_core`

## Requirements
- R1: After reset, `busy` and `done` are low and `digest` is all zeros.
- R2: A `start` pulse sampled high while `busy` is low makes `busy` high from the next clock edge.
- R3: `done` goes high for exactly one cycle, at the 65th rising edge after the edge that sampled `start`. `busy` falls on that same edge and is high on every edge in between.
- R4: The digest equals the MD5 hash of the message whose padded block was supplied. Input byte i sits at `block[8i+7:8i]`, and the 64-bit bit length sits in the last two words.
- R5: The digest is given most-significant-first as the conventional hex string. `digest[127:120]` is the low byte of the final A word and `digest[7:0]` is the high byte of the final D word.
- R6: A `start` pulse while `busy` is high is ignored, and the running hash finishes with the block captured first.
- R7: `digest` holds its value between completions, whatever `start` and `block` do.
- R8: A new `start` accepted on the cycle right after `done` yields a correct second digest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin hashing `block` when idle |
| block | input | 512 | Padded block, word j at bits 32j+31:32j |
| busy | output | 1 | High while the sixty-four steps and the final add run |
| done | output | 1 | One-cycle pulse when `digest` is updated |
| digest | output | 128 | Hash result, first byte in bits 127:120 |

## Verification
The assertions assume that `start` is only meaningful while idle. They also assume that `block` need not be held once it has been captured, so they check that the captured block stays unchanged for the whole run. The stimulus drives `start` for a single cycle and changes `block` and `start` in the middle of a run, so that the check for ignored starts is exercised. The bench builds each padded block itself from a short string of at most 55 bytes, so every stimulus is a valid one-block message.

// File: rtl/md5_core.sv
module md5_core #(
  parameter int WORD_W = 32,
  parameter int STEPS  = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [511:0]   block,
  output logic           busy,
  output logic           done,
  output logic [127:0]   digest
);
  localparam int CNT_W = $clog2(STEPS) + 1;
  localparam logic [WORD_W-1:0] IV_A = 32'h67452301;
  localparam logic [WORD_W-1:0] IV_B = 32'hefcdab89;
  localparam logic [WORD_W-1:0] IV_C = 32'h98badcfe;
  localparam logic [WORD_W-1:0] IV_D = 32'h10325476;

  logic [511:0]       msg;
  logic [WORD_W-1:0]  ra, rb, rc, rd;
  logic [CNT_W-1:0]   cnt;
  logic [WORD_W-1:0]  fmix, sum, nb;
  logic [3:0]         g;
  logic [4:0]         sh;
  logic [63:0]        dbl;

  wire [1:0] rnd = cnt[5:4];
  wire [3:0] idx = cnt[3:0];
  wire       last = (cnt == CNT_W'(STEPS));

  function automatic logic [31:0] kconst(input logic [5:0] i);
    case (i)
      6'd0:  return 32'hd76aa478;  6'd1:  return 32'he8c7b756;
      6'd2:  return 32'h242070db;  6'd3:  return 32'hc1bdceee;
      6'd4:  return 32'hf57c0faf;  6'd5:  return 32'h4787c62a;
      6'd6:  return 32'ha8304613;  6'd7:  return 32'hfd469501;
      6'd8:  return 32'h698098d8;  6'd9:  return 32'h8b44f7af;
      6'd10: return 32'hffff5bb1;  6'd11: return 32'h895cd7be;
      6'd12: return 32'h6b901122;  6'd13: return 32'hfd987193;
      6'd14: return 32'ha679438e;  6'd15: return 32'h49b40821;
      6'd16: return 32'hf61e2562;  6'd17: return 32'hc040b340;
      6'd18: return 32'h265e5a51;  6'd19: return 32'he9b6c7aa;
      6'd20: return 32'hd62f105d;  6'd21: return 32'h02441453;
      6'd22: return 32'hd8a1e681;  6'd23: return 32'he7d3fbc8;
      6'd24: return 32'h21e1cde6;  6'd25: return 32'hc33707d6;
      6'd26: return 32'hf4d50d87;  6'd27: return 32'h455a14ed;
      6'd28: return 32'ha9e3e905;  6'd29: return 32'hfcefa3f8;
      6'd30: return 32'h676f02d9;  6'd31: return 32'h8d2a4c8a;
      6'd32: return 32'hfffa3942;  6'd33: return 32'h8771f681;
      6'd34: return 32'h6d9d6122;  6'd35: return 32'hfde5380c;
      6'd36: return 32'ha4beea44;  6'd37: return 32'h4bdecfa9;
      6'd38: return 32'hf6bb4b60;  6'd39: return 32'hbebfbc70;
      6'd40: return 32'h289b7ec6;  6'd41: return 32'heaa127fa;
      6'd42: return 32'hd4ef3085;  6'd43: return 32'h04881d05;
      6'd44: return 32'hd9d4d039;  6'd45: return 32'he6db99e5;
      6'd46: return 32'h1fa27cf8;  6'd47: return 32'hc4ac5665;
      6'd48: return 32'hf4292244;  6'd49: return 32'h432aff97;
      6'd50: return 32'hab9423a7;  6'd51: return 32'hfc93a039;
      6'd52: return 32'h655b59c3;  6'd53: return 32'h8f0ccc92;
      6'd54: return 32'hffeff47d;  6'd55: return 32'h85845dd1;
      6'd56: return 32'h6fa87e4f;  6'd57: return 32'hfe2ce6e0;
      6'd58: return 32'ha3014314;  6'd59: return 32'h4e0811a1;
      6'd60: return 32'hf7537e82;  6'd61: return 32'hbd3af235;
      6'd62: return 32'h2ad7d2bb;  default: return 32'heb86d391;
    endcase
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  always_comb begin
    case (rnd)
      2'd0: begin fmix = (rb & rc) | (~rb & rd); g = idx;                end
      2'd1: begin fmix = (rb & rd) | (rc & ~rd); g = 4'(5 * idx + 1);    end
      2'd2: begin fmix = rb ^ rc ^ rd;           g = 4'(3 * idx + 5);    end
      default: begin fmix = rc ^ (rb | ~rd);     g = 4'(7 * idx);        end
    endcase
    case ({rnd, idx[1:0]})
      4'h0: sh = 5'd7;  4'h1: sh = 5'd12; 4'h2: sh = 5'd17; 4'h3: sh = 5'd22;
      4'h4: sh = 5'd5;  4'h5: sh = 5'd9;  4'h6: sh = 5'd14; 4'h7: sh = 5'd20;
      4'h8: sh = 5'd4;  4'h9: sh = 5'd11; 4'ha: sh = 5'd16; 4'hb: sh = 5'd23;
      4'hc: sh = 5'd6;  4'hd: sh = 5'd10; 4'he: sh = 5'd15; default: sh = 5'd21;
    endcase
  end

  assign sum = ra + fmix + kconst(cnt[5:0]) + msg[32*g +: 32];
  assign dbl = {sum, sum} << sh;
  assign nb  = rb + dbl[63:32];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; digest <= '0; msg <= '0; cnt <= '0;
      ra <= '0; rb <= '0; rc <= '0; rd <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          msg <= block; cnt <= '0; busy <= 1'b1;
          ra <= IV_A; rb <= IV_B; rc <= IV_C; rd <= IV_D;
        end
      end else if (last) begin
        digest <= {bswap(ra + IV_A), bswap(rb + IV_B), bswap(rc + IV_C), bswap(rd + IV_D)};
        busy <= 1'b0;
        done <= 1'b1;
      end else begin
        ra <= rd; rb <= nb; rc <= rb; rd <= rc;
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && !done));
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_msg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(msg));
  p_digest_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(digest));
endmodule

// File: tb/md5_core_bench.sv
module md5_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  localparam bit [8*44-1:0] STR [NV] = '{
    "", "a", "abc", "message digest", "abcdefghijklmnopqrstuvwxyz",
    "The quick brown fox jumps over the lazy dog"};
  localparam int LEN [NV] = '{0, 1, 3, 14, 26, 43};
  localparam bit [127:0] EXP [NV] = '{
    128'hd41d8cd98f00b204e9800998ecf8427e,
    128'h0cc175b9c0f1b6a831c399e269772661,
    128'h900150983cd24fb0d6963f7d28e17f72,
    128'hf96b697d7cb7938d525a2f31aaf161d0,
    128'hc3fcd3d76192e4007dfb496cca67e13b,
    128'h9e107d9d372bb6826bd81d3542a419d6};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [511:0] block = '0;
  logic busy, done;
  logic [127:0] digest;
  int n_chk = 0, n_bad = 0;

  md5_core u_md5_core (.clk(clk), .rst_n(rst_n), .start(start), .block(block),
                       .busy(busy), .done(done), .digest(digest));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [511:0] pad(input bit [8*44-1:0] s, input int len);
    logic [511:0] b = '0;
    for (int i = 0; i < len; i++) b[8*i +: 8] = s[8*(len-1-i) +: 8];
    b[8*len +: 8] = 8'h80;
    b[448 +: 64] = 64'(len * 8);
    return b;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Launches at a negedge, returns at the negedge after done; edges counts rising edges from the sampling one.
  task automatic run(input logic [511:0] b, output int edges, output logic busy_ok);
    block = b; start = 1'b1; edges = 0; busy_ok = 1'b1;
    do begin
      @(posedge clk); edges++;
      #1 start = 1'b0;
      if (!done && !busy) busy_ok = 1'b0;
    end while (!done && edges < 200);
    @(negedge clk);
  endtask

  initial begin
    int e; logic ok; logic [127:0] held;
    repeat (3) @(negedge clk);
    // R1
    check("R1 busy", 128'(busy), 128'd0);
    check("R1 done", 128'(done), 128'd0);
    check("R1 digest", digest, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run(pad(STR[v], LEN[v]), e, ok);
      check("R4 R5 digest", digest, EXP[v]);
      check("R3 latency", 128'(e), 128'd66); // sampling edge + 65
      check("R2 R3 busy held", 128'(ok), 128'd1);
      check("R3 busy low after done", 128'(busy), 128'd0);
    end

    // R2: busy visible one edge after start
    block = pad(STR[2], LEN[2]); start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    check("R2 busy", 128'(busy), 128'd1);
    // R6: start with a different block mid-run is ignored
    repeat (10) @(negedge clk);
    block = pad(STR[1], LEN[1]); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
    check("R6 ignored start", digest, EXP[2]);
    check("R3 done pulse width", 128'(done), 128'd1);
    @(negedge clk);
    check("R3 done falls", 128'(done), 128'd0);

    // R7: digest holds while idle with inputs moving
    held = digest;
    block = pad(STR[5], LEN[5]);
    repeat (8) @(negedge clk);
    check("R7 hold", digest, held);

    // R8: start on the cycle right after done
    run(pad(STR[3], LEN[3]), e, ok);
    run(pad(STR[4], LEN[4]), e, ok);
    check("R8 back to back", digest, EXP[4]);
    check("R8 latency", 128'(e), 128'd66);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule